// File: doc/BRIEF.md
# Integer ALU with Overflow Trap

This block is the combinational integer execution unit of a load/store RISC core. It takes two 32-bit operands, a 5-bit immediate shift count and a 4-bit operation code. It returns a 32-bit result and a one-bit overflow-trap flag in the same cycle. The operations are add and subtract, each in a trapping signed form and a silently wrapping form. There are four bitwise logic operations, signed and unsigned less-than compares, and left, logical-right and arithmetic-right shifts.

Each shift exists in two forms. One takes its count from the immediate shift port. The other takes its count from the low five bits of operand B. The shifted value is always operand A. Only the two trapping arithmetic codes can raise the trap flag. Instruction decode, the register file, multiply/divide, exception vectoring and pipeline control sit outside the block.

A thin top joins a control decoder to a datapath. The decoder turns the operation code into a small struct of strobes. The datapath holds a shared adder, a logic unit, a barrel shifter and a result multiplexer.

Top module: `int_alu`

## Requirements
- R1: Code 0 (signed add) returns A+B modulo 2^32. It raises the trap flag exactly when the true two's-complement sum lies outside the signed 32-bit range.
- R2: Code 1 (wrapping add) and code 3 (wrapping subtract) return A+B and A-B modulo 2^32. They hold the trap flag low for every operand pair.
- R3: Code 2 (signed subtract) returns A-B modulo 2^32. It raises the trap flag exactly when the true two's-complement difference lies outside the signed 32-bit range.
- R4: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOR(A,B). NOR with B equal to zero returns the bitwise NOT of A.
- R5: Code 10 shifts A left and code 11 shifts A right logically, both by the immediate count. Vacated positions are filled with zeros, and a count of zero returns A unchanged.
- R6: Code 12 shifts A right arithmetically by the immediate count, filling vacated positions with copies of A bit 31.
- R7: Codes 13, 14 and 15 are the left, logical-right and arithmetic-right shifts with the count taken from B bits [4:0]. Higher bits of B and the immediate count port have no effect, so counts wrap modulo 32.
- R8: Code 8 returns 1 when A is less than B as signed two's-complement numbers and 0 otherwise, with bits [31:1] zero.
- R9: Code 9 returns 1 when A is less than B as unsigned numbers and 0 otherwise, with bits [31:1] zero.
- R10: The trap flag is low for every code other than 0 and 2, including compares whose internal subtraction overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand; also the value being shifted |
| opB | input | 32 | Second operand; bits [4:0] give the count for register-count shifts |
| shamt | input | 5 | Immediate shift count |
| opSel | input | 4 | Operation code, values as listed in the requirements |
| result | output | 32 | Operation result |
| ovfTrap | output | 1 | Signed-overflow trap request |

## Verification
There is no register between the ports and both outputs, so the result and the trap flag are due in the same cycle as the operands and code that produce them. The bench changes inputs on the falling clock edge and samples a quarter period later, well before the next rising edge. Every check therefore sees settled values and never an edge race. Directed tasks cover the overflow boundaries, the wrap of register-count shifts and the compares. A sweep of pseudo-random operands then runs through every code against a 64-bit reference model.

// File: rtl/intalu_pkg.sv
package intalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD_TRAP  = 4'd0,
    OP_ADD_WRAP  = 4'd1,
    OP_SUB_TRAP  = 4'd2,
    OP_SUB_WRAP  = 4'd3,
    OP_AND       = 4'd4,
    OP_OR        = 4'd5,
    OP_XOR       = 4'd6,
    OP_NOR       = 4'd7,
    OP_LT_S      = 4'd8,
    OP_LT_U      = 4'd9,
    OP_SHL_IMM   = 4'd10,
    OP_SHRL_IMM  = 4'd11,
    OP_SHRA_IMM  = 4'd12,
    OP_SHL_REG   = 4'd13,
    OP_SHRL_REG  = 4'd14,
    OP_SHRA_REG  = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    UNIT_ADDER = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_CMP   = 2'd2,
    UNIT_SHIFT = 2'd3
  } unitSel_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_XOR = 2'd2,
    LOGIC_NOR = 2'd3
  } logicOp_e;

  typedef struct packed {
    logic     subtract;
    logic     trapEnable;
    unitSel_e unitSel;
    logicOp_e logicOp;
    logic     cmpUnsigned;
    logic     shiftRight;
    logic     shiftArith;
    logic     shiftFromReg;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import intalu_pkg::*;
(
  input  logic [3:0]  opSel,
  output aluStrobes_t strobes
);

  aluOp_e opCode;
  assign opCode = aluOp_e'(opSel);

  always_comb begin
    strobes              = '0;
    strobes.unitSel      = UNIT_ADDER;
    strobes.logicOp      = LOGIC_AND;
    unique case (opCode)
      OP_ADD_TRAP: strobes.trapEnable = 1'b1;
      OP_ADD_WRAP: ;
      OP_SUB_TRAP: begin
        strobes.subtract   = 1'b1;
        strobes.trapEnable = 1'b1;
      end
      OP_SUB_WRAP: strobes.subtract = 1'b1;
      OP_AND: begin
        strobes.unitSel = UNIT_LOGIC;
        strobes.logicOp = LOGIC_AND;
      end
      OP_OR: begin
        strobes.unitSel = UNIT_LOGIC;
        strobes.logicOp = LOGIC_OR;
      end
      OP_XOR: begin
        strobes.unitSel = UNIT_LOGIC;
        strobes.logicOp = LOGIC_XOR;
      end
      OP_NOR: begin
        strobes.unitSel = UNIT_LOGIC;
        strobes.logicOp = LOGIC_NOR;
      end
      OP_LT_S: begin
        strobes.unitSel  = UNIT_CMP;
        strobes.subtract = 1'b1;
      end
      OP_LT_U: begin
        strobes.unitSel     = UNIT_CMP;
        strobes.subtract    = 1'b1;
        strobes.cmpUnsigned = 1'b1;
      end
      OP_SHL_IMM: strobes.unitSel = UNIT_SHIFT;
      OP_SHRL_IMM: begin
        strobes.unitSel    = UNIT_SHIFT;
        strobes.shiftRight = 1'b1;
      end
      OP_SHRA_IMM: begin
        strobes.unitSel    = UNIT_SHIFT;
        strobes.shiftRight = 1'b1;
        strobes.shiftArith = 1'b1;
      end
      OP_SHL_REG: begin
        strobes.unitSel      = UNIT_SHIFT;
        strobes.shiftFromReg = 1'b1;
      end
      OP_SHRL_REG: begin
        strobes.unitSel      = UNIT_SHIFT;
        strobes.shiftRight   = 1'b1;
        strobes.shiftFromReg = 1'b1;
      end
      OP_SHRA_REG: begin
        strobes.unitSel      = UNIT_SHIFT;
        strobes.shiftRight   = 1'b1;
        strobes.shiftArith   = 1'b1;
        strobes.shiftFromReg = 1'b1;
      end
      default: ;
    endcase
  end

  // Only the two trapping arithmetic codes may arm the trap (R10)
  always_comb begin
    if (opSel != 4'd0 && opSel != 4'd2) begin
      p_trap_armed_r10: assert (!strobes.trapEnable)
        else $error("trap armed for non-trapping code");
    end
  end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] dataIn,
  input  logic [SHW-1:0]   amount,
  input  logic             shiftRight,
  input  logic             shiftArith,
  output logic [WIDTH-1:0] dataOut
);

  function automatic logic [WIDTH-1:0] revBits(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  logic [WIDTH-1:0] rightIn;
  logic             fillBit;

  // Left shifts run through the right-shift chain on a reversed word
  assign rightIn = shiftRight ? dataIn : revBits(dataIn);
  assign fillBit = shiftRight & shiftArith & dataIn[WIDTH-1];

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    logic [WIDTH-1:0] stIn;
    logic [WIDTH-1:0] stOut;
    if (s == 0) begin : g_first
      assign stIn = rightIn;
    end else begin : g_next
      assign stIn = g_stage[s-1].stOut;
    end
    assign stOut = amount[s] ? {{STEP{fillBit}}, stIn[WIDTH-1:STEP]} : stIn;
  end

  logic [WIDTH-1:0] chainOut;
  assign chainOut = g_stage[SHW-1].stOut;
  assign dataOut  = shiftRight ? chainOut : revBits(chainOut);

  always_comb begin
    if (shiftRight && !shiftArith && amount != '0) begin
      p_lsr_zero_fill_r5: assert (dataOut[WIDTH-1] == 1'b0)
        else $error("logical right shift did not zero-fill");
    end
    if (!shiftRight && amount != '0) begin
      p_lsl_zero_fill_r5: assert (dataOut[0] == 1'b0)
        else $error("left shift did not zero-fill");
    end
    if (shiftRight && shiftArith) begin
      p_asr_sign_kept_r6: assert (dataOut[WIDTH-1] == dataIn[WIDTH-1])
        else $error("arithmetic shift lost the sign");
    end
    if (amount == '0) begin
      p_zero_count_r5: assert (dataOut == dataIn)
        else $error("zero count altered data");
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import intalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamt,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             ovfTrap
);

  // Shared adder: subtraction as A + ~B + 1
  logic [WIDTH-1:0] bOperand;
  logic [WIDTH:0]   sumWide;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             signedOvf;
  logic             lessThan;

  assign bOperand = strobes.subtract ? ~opB : opB;
  assign sumWide  = {1'b0, opA} + {1'b0, bOperand} + {{WIDTH{1'b0}}, strobes.subtract};
  assign sum      = sumWide[WIDTH-1:0];
  assign carryOut = sumWide[WIDTH];

  assign signedOvf = (opA[WIDTH-1] == bOperand[WIDTH-1]) && (sum[WIDTH-1] != opA[WIDTH-1]);
  assign lessThan  = strobes.cmpUnsigned ? ~carryOut : (sum[WIDTH-1] ^ signedOvf);

  // Logic unit
  logic [WIDTH-1:0] logicOut;
  always_comb begin
    unique case (strobes.logicOp)
      LOGIC_AND: logicOut = opA & opB;
      LOGIC_OR:  logicOut = opA | opB;
      LOGIC_XOR: logicOut = opA ^ opB;
      LOGIC_NOR: logicOut = ~(opA | opB);
      default:   logicOut = '0;
    endcase
  end

  // Shifter, count from the immediate port or the low bits of B
  logic [SHW-1:0]   shiftCount;
  logic [WIDTH-1:0] shiftOut;
  assign shiftCount = strobes.shiftFromReg ? opB[SHW-1:0] : shamt;

  alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .dataIn     (opA),
    .amount     (shiftCount),
    .shiftRight (strobes.shiftRight),
    .shiftArith (strobes.shiftArith),
    .dataOut    (shiftOut)
  );

  always_comb begin
    unique case (strobes.unitSel)
      UNIT_ADDER: result = sum;
      UNIT_LOGIC: result = logicOut;
      UNIT_CMP:   result = {{(WIDTH-1){1'b0}}, lessThan};
      UNIT_SHIFT: result = shiftOut;
      default:    result = '0;
    endcase
  end

  assign ovfTrap = strobes.trapEnable & signedOvf;

  always_comb begin
    if (!strobes.trapEnable) begin
      p_no_trap_wrap_r2: assert (!ovfTrap)
        else $error("trap raised with trapping disabled");
    end
    if (ovfTrap) begin
      p_trap_sign_flip_r1: assert (result[WIDTH-1] != opA[WIDTH-1])
        else $error("trap raised without sign change");
    end
    if (strobes.unitSel == UNIT_CMP) begin
      p_cmp_single_bit_r8: assert (result[WIDTH-1:1] == '0)
        else $error("compare result wider than one bit");
    end
    if (strobes.unitSel == UNIT_LOGIC && strobes.logicOp == LOGIC_NOR && opB == '0) begin
      p_nor_is_not_r4: assert (result == ~opA)
        else $error("NOR with zero is not NOT");
    end
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import intalu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shamt,
  input  logic [3:0]       opSel,
  output logic [WIDTH-1:0] result,
  output logic             ovfTrap
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .opA     (opA),
    .opB     (opB),
    .shamt   (shamt),
    .strobes (strobes),
    .result  (result),
    .ovfTrap (ovfTrap)
  );

  always_comb begin
    if (opSel != 4'd0 && opSel != 4'd2) begin
      p_flag_scope_r10: assert (!ovfTrap)
        else $error("trap flag raised by non-trapping code");
    end
  end

endmodule

// File: tb/tb_int_alu.sv
module tb_int_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA, opB;
  logic [4:0]  shamt;
  logic [3:0]  opSel;
  logic [31:0] result;
  logic        ovfTrap;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  int_alu dut (
    .opA(opA), .opB(opB), .shamt(shamt), .opSel(opSel),
    .result(result), .ovfTrap(ovfTrap)
  );

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd3: return "R2";
      4'd2: return "R3";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4";
      4'd8: return "R8";
      4'd9: return "R9";
      4'd10, 4'd11: return "R5";
      4'd12: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Reference model built from the requirements with 64-bit arithmetic
  function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [4:0] sh);
    longint sa, sb, w;
    longint maxS, minS;
    logic [31:0] r;
    logic        o;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    maxS = 64'sd2147483647;
    minS = -64'sd2147483648;
    o = 1'b0;
    r = '0;
    case (op)
      4'd0: begin w = sa + sb; r = a + b; o = (w > maxS) || (w < minS); end
      4'd1: r = a + b;
      4'd2: begin w = sa - sb; r = a - b; o = (w > maxS) || (w < minS); end
      4'd3: r = a - b;
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = ~(a | b);
      4'd8: r = {31'b0, (sa < sb)};
      4'd9: r = {31'b0, (a < b)};
      4'd10: r = a << sh;
      4'd11: r = a >> sh;
      4'd12: r = 32'($signed(a) >>> sh);
      4'd13: r = a << b[4:0];
      4'd14: r = a >> b[4:0];
      default: r = 32'($signed(a) >>> b[4:0]);
    endcase
    return {o, r};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] sh);
    @(negedge clk);
    opSel = op; opA = a; opB = b; shamt = sh;
    #5;  // combinational: sample a quarter period after the falling edge
  endtask

  task automatic expect_out(input string tag, input logic [31:0] expRes, input logic expOvf);
    checks++;
    if (result !== expRes || ovfTrap !== expOvf) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: got res=%h ovf=%b exp res=%h ovf=%b",
               tag, opSel, opA, opB, shamt, result, ovfTrap, expRes, expOvf);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [4:0] sh,
                     input logic [31:0] expRes, input logic expOvf);
    drive(op, a, b, sh);
    expect_out(tag, expRes, expOvf);
  endtask

  task automatic t_reset_state();
    run("R1", 4'd0, 32'h0, 32'h0, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_add_trap();  // R1
    run("R1", 4'd0, 32'h7fffffff, 32'h00000001, 5'd0, 32'h80000000, 1'b1);
    run("R1", 4'd0, 32'h80000000, 32'h80000000, 5'd0, 32'h00000000, 1'b1);
    run("R1", 4'd0, 32'hffffffff, 32'h00000001, 5'd0, 32'h00000000, 1'b0);
    run("R1", 4'd0, 32'h12345678, 32'h11111111, 5'd0, 32'h23456789, 1'b0);
  endtask

  task automatic t_wrap_forms();  // R2
    run("R2", 4'd1, 32'h7fffffff, 32'h00000001, 5'd0, 32'h80000000, 1'b0);
    run("R2", 4'd1, 32'h80000000, 32'h80000000, 5'd0, 32'h00000000, 1'b0);
    run("R2", 4'd3, 32'h80000000, 32'h00000001, 5'd0, 32'h7fffffff, 1'b0);
    run("R2", 4'd3, 32'h00000000, 32'h00000001, 5'd0, 32'hffffffff, 1'b0);
  endtask

  task automatic t_sub_trap();  // R3
    run("R3", 4'd2, 32'h80000000, 32'h00000001, 5'd0, 32'h7fffffff, 1'b1);
    run("R3", 4'd2, 32'h00000000, 32'h80000000, 5'd0, 32'h80000000, 1'b1);
    run("R3", 4'd2, 32'h00000005, 32'h00000007, 5'd0, 32'hfffffffe, 1'b0);
    run("R3", 4'd2, 32'h7fffffff, 32'hffffffff, 5'd0, 32'h80000000, 1'b1);
  endtask

  task automatic t_logic();  // R4
    run("R4", 4'd4, 32'hf0f0f0f0, 32'hff00ff00, 5'd0, 32'hf000f000, 1'b0);
    run("R4", 4'd5, 32'hf0f0f0f0, 32'hff00ff00, 5'd0, 32'hfff0fff0, 1'b0);
    run("R4", 4'd6, 32'hf0f0f0f0, 32'hff00ff00, 5'd0, 32'h0ff00ff0, 1'b0);
    run("R4", 4'd7, 32'h12345678, 32'h00000000, 5'd0, 32'hedcba987, 1'b0);
    run("R4", 4'd7, 32'hf0f0f0f0, 32'h0f0f0f0f, 5'd0, 32'h00000000, 1'b0);
  endtask

  task automatic t_shift_imm();  // R5, R6
    run("R5", 4'd10, 32'h80000001, 32'h0, 5'd1,  32'h00000002, 1'b0);
    run("R5", 4'd11, 32'h80000000, 32'h0, 5'd31, 32'h00000001, 1'b0);
    run("R5", 4'd10, 32'hdeadbeef, 32'h0, 5'd0,  32'hdeadbeef, 1'b0);
    run("R5", 4'd11, 32'hdeadbeef, 32'h0, 5'd0,  32'hdeadbeef, 1'b0);
    run("R6", 4'd12, 32'h80000000, 32'h0, 5'd4,  32'hf8000000, 1'b0);
    run("R6", 4'd12, 32'h40000000, 32'h0, 5'd4,  32'h04000000, 1'b0);
    run("R6", 4'd12, 32'hffffffff, 32'h0, 5'd31, 32'hffffffff, 1'b0);
  endtask

  task automatic t_shift_reg();  // R7: count from B[4:0], immediate ignored
    run("R7", 4'd13, 32'h00000001, 32'h00000023, 5'd0,  32'h00000008, 1'b0);
    run("R7", 4'd13, 32'h00000001, 32'h00000001, 5'd7,  32'h00000002, 1'b0);
    run("R7", 4'd14, 32'h80000000, 32'hffffffe1, 5'd9,  32'h40000000, 1'b0);
    run("R7", 4'd15, 32'h80000000, 32'h00000020, 5'd3,  32'h80000000, 1'b0);
    run("R7", 4'd15, 32'hf0000000, 32'h00000004, 5'd31, 32'hff000000, 1'b0);
  endtask

  task automatic t_compare();  // R8, R9
    run("R8", 4'd8, 32'hffffffff, 32'h00000001, 5'd0, 32'h1, 1'b0);
    run("R8", 4'd8, 32'h00000001, 32'hffffffff, 5'd0, 32'h0, 1'b0);
    run("R8", 4'd8, 32'h80000000, 32'h7fffffff, 5'd0, 32'h1, 1'b0);
    run("R8", 4'd8, 32'h00000005, 32'h00000005, 5'd0, 32'h0, 1'b0);
    run("R9", 4'd9, 32'hffffffff, 32'h00000001, 5'd0, 32'h0, 1'b0);
    run("R9", 4'd9, 32'h00000001, 32'hffffffff, 5'd0, 32'h1, 1'b0);
    run("R9", 4'd9, 32'h00000000, 32'h00000000, 5'd0, 32'h0, 1'b0);
  endtask

  task automatic t_flag_scope();  // R10
    run("R10", 4'd4, 32'h7fffffff, 32'h00000001, 5'd0, 32'h00000001, 1'b0);
    run("R10", 4'd8, 32'h80000000, 32'h00000001, 5'd0, 32'h00000001, 1'b0);
    run("R10", 4'd9, 32'h7fffffff, 32'hffffffff, 5'd0, 32'h00000001, 1'b0);
    run("R10", 4'd12, 32'h80000000, 32'h7fffffff, 5'd1, 32'hc0000000, 1'b0);
  endtask

  task automatic t_sweep();  // every code against the reference model
    logic [31:0] lfsr;
    logic [32:0] expv;
    lfsr = 32'hace1_2468;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a, b;
      logic [4:0]  sh;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (i % 7 == 0) ? {a[31], ~a[30:0]} : lfsr * 32'd2654435761;
      sh = lfsr[9:5];
      expv = model(4'(i % 16), a, b, sh);
      drive(4'(i % 16), a, b, sh);
      expect_out(tagOf(4'(i % 16)), expv[31:0], expv[32]);
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    opA = '0; opB = '0; shamt = '0; opSel = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_add_trap();
    t_wrap_forms();
    t_sub_trap();
    t_logic();
    t_shift_imm();
    t_shift_reg();
    t_compare();
    t_flag_scope();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule